// File: doc/BRIEF.md
# Dual-Framing Serial Flash Read Engine

This block is the device side of a serial flash read port. It watches a chip select, a serial clock and four data lines, all oversampled by a fast system clock through a short synchronizer. A transaction carries one opcode, and two opcodes are understood. One is a fast read, which takes a 24-bit start address and a dummy period and then returns bytes from a small internal array for as long as chip select stays low. The other is a reset that puts the port back into single-line framing.

The same state machine handles two framings. In single-line framing, bits arrive on line 0 and leave on line 1. In four-line framing, each clock carries a nibble in both directions. A strobe from the surrounding chip moves the port into four-line framing. Per-block lock flags force locked bytes to read as zero. A load port writes the array directly so that a test can fill it.

The read address steps by one for each byte. Only its low bits select an array entry, so the array repeats across the address space, and the full 24-bit pointer rolls over from its top value to zero. Data lines are outputs only while read data is on them. The house stream handshake does not fit a port whose pacing is set entirely by the external serial clock, so all pins are plain.

Top module: `sqf_read_slave`

## Requirements
- R1: After reset the port uses single-line framing and all four output enables are 0.
- R2: A one-cycle pulse on `quad_enter` while chip select is high selects four-line framing for later transactions.
- R3: Single-line read: opcode 0x0B, then 24 address bits, then 8 dummy clocks, all sampled MSB first from line 0 on rising clock edges. Each falling edge after that drives the next data bit, MSB first, on line 1, with `sio_oe` = 4'b0010.
- R4: Four-line read: opcode, address and dummy use 2, 6 and 2 clocks, each clock carrying a nibble (most significant nibble first) on lines 3..0. Each byte goes out as its high nibble and then its low nibble, one per falling edge, with `sio_oe` = 4'hF.
- R5: The pointer advances by one after each whole byte. Array index = address mod DEPTH, and the 24-bit pointer wraps from 0xFFFFFF to 0x000000.
- R6: A byte whose index lies in block (index / BLK_BYTES) with `lock_blk` bit set reads as 0x00.
- R7: A rising chip select ends any transaction. The engine returns to idle, the enables drop to 0, and the next transaction starts from a fresh opcode.
- R8: Opcode 0xFF selects single-line framing. In four-line framing it is accepted after its 2 clocks (lines held high), so an 8-clock form with all lines high also works. Nothing is driven for the rest of that transaction.
- R9: Any other opcode causes the rest of the transaction to be ignored, with enables held at 0.
- R10: The clock may idle low or high between transactions. Both work for reads.
- R11: A write on the load port (`ld_en`, `ld_addr`, `ld_data`) stores a byte that later reads return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| sio_in | input | 4 | Input values of the four data lines |
| quad_enter | input | 1 | Strobe that selects four-line framing (used while cs_n high) |
| lock_blk | input | NBLK | Read-lock flag per array block |
| ld_en | input | 1 | Load-port write enable |
| ld_addr | input | IDX_W | Load-port array index |
| ld_data | input | 8 | Load-port data byte |
| sio_out | output | 4 | Values driven on the data lines |
| sio_oe | output | 4 | Per-line output enable |

## Verification
Every serial-pin edge passes through two synchronizer flops and one edge-detect flop. So a data output or an enable change appears on the third system clock edge after a sck or cs_n transition. The bench holds each serial half-period for six system clocks and compares the lines only at the end of the half-period, well after that three-cycle delay. The rule for released drivers after chip select rises is sampled eight clocks later, and the reset state is sampled after reset has been applied for several cycles.

// File: rtl/sqf_pkg.sv
package sqf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA, ST_SKIP
  } sqf_state_e;

  localparam logic [7:0] OP_FAST_READ  = 8'h0B;
  localparam logic [7:0] OP_SINGLE_RST = 8'hFF;
  localparam logic [3:0] OE_SINGLE     = 4'b0010;
  localparam logic [3:0] OE_QUAD       = 4'b1111;
endpackage

// File: rtl/sqf_sync.sv
module sqf_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES*W-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= INIT;
        else        chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= {STAGES{INIT}};
        else        chain <= {chain[(STAGES-1)*W-1:0], d};
    end
  endgenerate

  assign q = chain[STAGES*W-1 -: W];
endmodule

// File: rtl/sqf_byte_array.sv
module sqf_byte_array #(
  parameter int DEPTH = 256,
  parameter int BLK_BYTES = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int BOFF_W = $clog2(BLK_BYTES),
  localparam int NBLK = DEPTH / BLK_BYTES
) (
  input  logic             clk,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_addr,
  input  logic [7:0]       ld_data,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [NBLK-1:0]  lock_blk,
  output logic [7:0]       rd_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk)
    if (ld_en) mem[ld_addr] <= ld_data;

  always_comb begin
    if (lock_blk[rd_idx[IDX_W-1:BOFF_W]]) rd_data = 8'h00;
    else                                  rd_data = mem[rd_idx];
  end
endmodule

// File: rtl/sqf_out_lane.sv
module sqf_out_lane (
  input  logic [7:0] byte_v,
  input  logic [2:0] piece,
  input  logic       quad,
  output logic [3:0] lanes,
  output logic       last
);
  always_comb begin
    if (quad) begin
      lanes = piece[0] ? byte_v[3:0] : byte_v[7:4];
      last  = piece[0];
    end else begin
      lanes = {2'b00, byte_v[3'd7 - piece], 1'b0};
      last  = (piece == 3'd7);
    end
  end
endmodule

// File: rtl/sqf_read_slave.sv
module sqf_read_slave
  import sqf_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int BLK_BYTES = 64,
  parameter int ADDR_W = 24,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int NBLK = DEPTH / BLK_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sck,
  input  logic [3:0]       sio_in,
  input  logic             quad_enter,
  input  logic [NBLK-1:0]  lock_blk,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_addr,
  input  logic [7:0]       ld_data,
  output logic [3:0]       sio_out,
  output logic [3:0]       sio_oe
);
  logic [3:0]        sio_s;
  logic              sck_s, cs_s, sck_q;
  sqf_state_e        state;
  logic              quad, drv;
  logic [5:0]        cnt, cnt_nx, len;
  logic [ADDR_W-1:0] sh, shv, ptr;
  logic [2:0]        piece;
  logic [3:0]        dout, lanes;
  logic [7:0]        byte_q;
  logic              rise, fall, done, last;

  sqf_sync #(.W(6), .STAGES(SYNC_STAGES), .INIT(6'b000001)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sio_in, sck, cs_n}), .q({sio_s, sck_s, cs_s})
  );

  sqf_byte_array #(.DEPTH(DEPTH), .BLK_BYTES(BLK_BYTES)) u_array (
    .clk(clk), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_idx(ptr[IDX_W-1:0]), .lock_blk(lock_blk), .rd_data(byte_q)
  );

  sqf_out_lane u_lane (
    .byte_v(byte_q), .piece(piece), .quad(quad), .lanes(lanes), .last(last)
  );

  assign rise   = sck_s & ~sck_q;
  assign fall   = ~sck_s & sck_q;
  assign shv    = quad ? {sh[ADDR_W-5:0], sio_s} : {sh[ADDR_W-2:0], sio_s[0]};
  assign cnt_nx = cnt + (quad ? 6'd4 : 6'd1);
  assign done   = (cnt_nx == len);

  always_comb begin
    case (state)
      ST_ADDR: len = 6'(ADDR_W);
      default: len = 6'd8;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      state <= ST_IDLE;
      quad  <= 1'b0;
      drv   <= 1'b0;
      cnt   <= '0;
      sh    <= '0;
      ptr   <= '0;
      piece <= '0;
      dout  <= '0;
    end else begin
      sck_q <= sck_s;
      if (cs_s) begin
        state <= ST_IDLE;
        cnt   <= '0;
        drv   <= 1'b0;
        dout  <= '0;
        piece <= '0;
        if (quad_enter) quad <= 1'b1;
      end else begin
        if (rise) begin
          case (state)
            ST_IDLE, ST_CMD: begin
              sh <= shv;
              if (done) begin
                cnt <= '0;
                if (shv[7:0] == OP_FAST_READ) begin
                  state <= ST_ADDR;
                end else begin
                  state <= ST_SKIP;
                  if (shv[7:0] == OP_SINGLE_RST) quad <= 1'b0;
                end
              end else begin
                cnt   <= cnt_nx;
                state <= ST_CMD;
              end
            end
            ST_ADDR: begin
              sh <= shv;
              if (done) begin
                ptr   <= shv;
                cnt   <= '0;
                state <= ST_DUMMY;
              end else begin
                cnt <= cnt_nx;
              end
            end
            ST_DUMMY: begin
              if (done) begin
                cnt   <= '0;
                piece <= '0;
                state <= ST_DATA;
              end else begin
                cnt <= cnt_nx;
              end
            end
            default: ;
          endcase
        end
        if (fall && state == ST_DATA) begin
          dout <= lanes;
          drv  <= 1'b1;
          if (last) begin
            ptr   <= ptr + 1'b1;
            piece <= '0;
          end else begin
            piece <= piece + 3'd1;
          end
        end
      end
    end
  end

  assign sio_out = dout;
  assign sio_oe  = drv ? (quad ? OE_QUAD : OE_SINGLE) : 4'b0000;
endmodule

// File: rtl/sqf_read_slave_chk.sv
module sqf_read_slave_chk
  import sqf_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int BLK_BYTES = 64,
  parameter int ADDR_W = 24,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int BOFF_W = $clog2(BLK_BYTES),
  localparam int NBLK = DEPTH / BLK_BYTES
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_s,
  input logic              quad_enter,
  input logic              quad,
  input sqf_state_e        state,
  input logic [ADDR_W-1:0] ptr,
  input logic [NBLK-1:0]   lock_blk,
  input logic [7:0]        byte_q,
  input logic [3:0]        sio_oe
);
  assert_single_after_reset_R1: assert property (@(posedge clk)
    !rst_n |=> !quad);

  assert_quad_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && quad_enter) |=> quad);

  assert_single_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !quad |-> (sio_oe == 4'b0000 || sio_oe == OE_SINGLE));

  assert_quad_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (quad && sio_oe != 4'b0000) |-> sio_oe == OE_QUAD);

  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && $past(state) == ST_DATA && !$stable(ptr))
      |-> ptr == ADDR_W'($past(ptr) + 1'b1));

  assert_lock_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_blk[ptr[IDX_W-1:BOFF_W]] |-> byte_q == 8'h00);

  assert_abort_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (state == ST_IDLE && sio_oe == 4'b0000));
endmodule

bind sqf_read_slave sqf_read_slave_chk #(
  .DEPTH(DEPTH), .BLK_BYTES(BLK_BYTES), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .quad_enter(quad_enter),
  .quad(quad), .state(state), .ptr(ptr), .lock_blk(lock_blk),
  .byte_q(byte_q), .sio_oe(sio_oe)
);

// File: tb/test_sqf_read_slave.sv
`timescale 1ns/1ps
module test_sqf_read_slave;
  localparam int DEPTH = 256;
  localparam int BLK = 64;
  localparam int NBLK = DEPTH / BLK;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic [3:0] sio_in = 4'h0;
  logic quad_enter = 1'b0;
  logic [NBLK-1:0] lock_blk = '0;
  logic ld_en = 1'b0;
  logic [7:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic [3:0] sio_out, sio_oe;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] mem_m [DEPTH];

  always #5 clk = ~clk;

  sqf_read_slave #(.DEPTH(DEPTH), .BLK_BYTES(BLK)) i_sqf_read_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sio_in(sio_in),
    .quad_enter(quad_enter), .lock_blk(lock_blk), .ld_en(ld_en),
    .ld_addr(ld_addr), .ld_data(ld_data), .sio_out(sio_out), .sio_oe(sio_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [23:0] a);
    int idx = int'(a) % DEPTH;
    return lock_blk[idx / BLK] ? 8'h00 : mem_m[idx];
  endfunction

  task automatic clk_cycle(input logic [3:0] d);
    sio_in = d; sck = 1'b0; tick(H);
    sck = 1'b1; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit q);
    if (q) begin
      clk_cycle(b[7:4]);
      clk_cycle(b[3:0]);
    end else begin
      for (int i = 7; i >= 0; i--) clk_cycle({3'b110, b[i]});
    end
  endtask

  task automatic begin_tx(input bit m3);
    sck = m3; tick(4);
    cs_n = 1'b0; tick(4);
  endtask

  task automatic end_tx(input bit m3, input string req);
    if (!m3) begin sck = 1'b0; tick(H); end
    cs_n = 1'b1; tick(8);
    chk(req, {4'h0, sio_oe}, 8'h00);
  endtask

  // compare every data piece at the end of the low half of sck
  task automatic read_bytes(input logic [23:0] a, input int n, input bit q, input string req);
    for (int k = 0; k < n; k++) begin
      logic [7:0] e = exp_byte(a + 24'(k));
      for (int p = 0; p < (q ? 2 : 8); p++) begin
        sck = 1'b0; tick(H);
        if (q) begin
          chk(req, {4'h0, sio_oe}, 8'h0F);
          chk(req, {4'h0, sio_out}, {4'h0, (p == 0) ? e[7:4] : e[3:0]});
        end else begin
          chk(req, {4'h0, sio_oe}, 8'h02);
          chk(req, {7'h0, sio_out[1]}, {7'h0, e[7-p]});
        end
        sck = 1'b1; tick(H);
      end
    end
  endtask

  task automatic do_read(input bit m3, input bit q, input logic [23:0] a,
                         input int n, input string req);
    begin_tx(m3);
    send_byte(8'h0B, q);
    send_byte(a[23:16], q);
    send_byte(a[15:8], q);
    send_byte(a[7:0], q);
    send_byte(8'h00, q);
    read_bytes(a, n, q, req);
    end_tx(m3, "R7");
  endtask

  task automatic no_drive(input int clocks, input string req);
    for (int i = 0; i < clocks; i++) begin
      sck = 1'b0; tick(H);
      chk(req, {4'h0, sio_oe}, 8'h00);
      sck = 1'b1; tick(H);
    end
  endtask

  task automatic pulse_quad();
    quad_enter = 1'b1; tick(1);
    quad_enter = 1'b0; tick(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(5);
    chk("R1 reset", {4'h0, sio_oe}, 8'h00);
    rst_n = 1'b1; tick(2);
    chk("R1 after reset", {4'h0, sio_oe}, 8'h00);

    // R11: preload through the load port
    for (int i = 0; i < DEPTH; i++) begin
      mem_m[i] = 8'((i * 37 + 5) & 255);
      ld_en = 1'b1; ld_addr = 8'(i); ld_data = mem_m[i];
      tick(1);
    end
    ld_en = 1'b0; tick(2);

    do_read(1'b0, 1'b0, 24'h000010, 4, "R3 R11 single mode0");
    do_read(1'b1, 1'b0, 24'hFFFFFE, 3, "R5 R10 single mode3 wrap");

    lock_blk = 4'b0010;
    do_read(1'b0, 1'b0, 24'h00003E, 4, "R6 single lock");
    lock_blk = '0;

    // R9: unknown opcode ignored
    begin_tx(1'b0);
    send_byte(8'h9F, 1'b0);
    no_drive(16, "R9 unknown opcode");
    end_tx(1'b0, "R9");

    // R7: abort part way through a byte, then a fresh read
    begin_tx(1'b0);
    send_byte(8'h0B, 1'b0);
    send_byte(8'h00, 1'b0); send_byte(8'h00, 1'b0); send_byte(8'h20, 1'b0);
    send_byte(8'h00, 1'b0);
    read_bytes(24'h000020, 1, 1'b0, "R7 before abort");
    sck = 1'b0; tick(H); sck = 1'b1; tick(H);
    cs_n = 1'b1; tick(4);
    chk("R7 abort release", {4'h0, sio_oe}, 8'h00);
    tick(4);
    do_read(1'b0, 1'b0, 24'h000021, 2, "R7 fresh read");

    // R2/R4: four-line framing
    pulse_quad();
    do_read(1'b0, 1'b1, 24'h000080, 3, "R2 R4 quad mode0");
    lock_blk = 4'b1000;
    do_read(1'b0, 1'b1, 24'h0000BE, 3, "R4 R6 quad lock");
    lock_blk = '0;
    do_read(1'b1, 1'b1, 24'hFFFFFF, 2, "R5 R10 quad mode3 wrap");

    // R8: two-clock reset form, then single-line read must work
    begin_tx(1'b0);
    send_byte(8'hFF, 1'b1);
    no_drive(4, "R8 quad reset ignore");
    end_tx(1'b0, "R8");
    do_read(1'b0, 1'b0, 24'h000005, 2, "R8 single after quad reset");

    // R8: eight-clock form with all lines high while in four-line framing
    pulse_quad();
    begin_tx(1'b1);
    for (int i = 0; i < 8; i++) clk_cycle(4'hF);
    no_drive(4, "R8 eight clock form ignore");
    end_tx(1'b1, "R8");
    do_read(1'b1, 1'b0, 24'h0000F0, 2, "R8 single after eight clock reset");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule